// File: doc/BRIEF.md
# Fully Associative Address-Space-Tagged Translation Buffer

This block caches virtual-to-physical page translations for a memory system where software handles refills. A lookup presents a virtual page number, the identifier of the running address space and whether the access is a write. In the same cycle, the block answers in one of four ways: a hit with the physical frame number, a miss, a protection fault, or a dirty-update exception. Each entry is tagged with an address-space identifier. Translations belonging to several processes can therefore sit side by side, even when they share a virtual page number.

Privileged software installs an entry by writing an index together with the page number, frame number, identifier, permission bits, dirty bit and valid bit. To pick that index, software reads the block's suggested replacement slot. A parameter chooses how that slot is found: either least-recently-used ordering or a free-running pseudo-random sequence. The lowest `WIRED` slots are permanent. They are never suggested for replacement, and they keep their translations through a flush, so the miss handler's own pages always translate. A flush is started by an explicit command. When `FLUSH_ON_PTBR` is set, a write of the page-table base register also starts one.

The lookup interface follows valid/ready rules. A request is accepted in a cycle where both `lkp_valid` and `lkp_ready` are high, and the response is valid in that same cycle. `lkp_ready` drops in any cycle that carries an entry write or a flush. In such a cycle the requester must hold its request, and every response output reads zero.

Top module: `asid_tlb`

## Requirements
- R1: An accepted lookup hits only on an entry that meets all three conditions: it is valid, its VPN equals `lkp_vpn`, and its ASID equals `lkp_asid`. On a hit, `rsp_hit` is 1 and `rsp_pfn` carries the entry's frame number in the same cycle.
- R2: Two valid entries with the same VPN and different ASIDs each translate for their own ASID only.
- R3: An accepted lookup that matches no entry sets `rsp_miss`. In that case `rsp_hit` is 0 and `rsp_pfn` is 0. Exactly one of `rsp_hit`, `rsp_miss`, `rsp_prot_fault` and `rsp_dirty_exc` is high per accepted lookup.
- R4: In the permission field, `wr_prot` bit 0 permits reads and bit 1 permits writes. A matching access whose permission bit is clear raises `rsp_prot_fault` instead of a hit.
- R5: A permitted write that matches an entry whose dirty bit is 0 raises `rsp_dirty_exc` instead of a hit. A read of the same entry hits.
- R6: When several entries match, the lowest index supplies the result and `rsp_multi_hit` is 1.
- R7: `flush_cmd` clears the valid bit of every entry at index `WIRED` or above. Entries below `WIRED` keep translating.
- R8: With `FLUSH_ON_PTBR` set, `ptbr_wr` performs the same flush as `flush_cmd`.
- R9: `victim_idx` is never below `WIRED`. If any non-wired entry is invalid, `victim_idx` is the lowest such index.
- R10: With the LRU policy and every non-wired entry valid, `victim_idx` is the non-wired entry touched longest ago. An entry is touched by an entry write or by a lookup with `rsp_hit`.
- R11: With the random policy and every non-wired entry valid, `victim_idx` comes from a free-running LFSR folded into the range `WIRED` to `ENTRIES-1`, and it changes over time.
- R12: `lkp_ready` is 0 in any cycle with `wr_en`, `flush_cmd`, or `ptbr_wr` (when flush-enabled). Whenever no lookup is accepted, all response outputs are 0.
- R13: After reset every entry is invalid, so every lookup misses and `victim_idx` equals `WIRED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lkp_valid | input | 1 | Lookup request present |
| lkp_ready | output | 1 | Lookup can be accepted this cycle |
| lkp_vpn | input | VPN_W | Requested virtual page number |
| lkp_asid | input | ASID_W | Current address-space identifier |
| lkp_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_pfn | output | PFN_W | Frame number on a hit, else 0 |
| rsp_miss | output | 1 | No matching entry; software refill needed |
| rsp_prot_fault | output | 1 | Matching entry forbids this access |
| rsp_dirty_exc | output | 1 | Write to a clean entry |
| rsp_multi_hit | output | 1 | More than one entry matched |
| wr_en | input | 1 | Install an entry this cycle |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | VPN_W | Virtual page number to store |
| wr_pfn | input | PFN_W | Frame number to store |
| wr_asid | input | ASID_W | Address-space identifier to store |
| wr_prot | input | 2 | Bit 0 read permit, bit 1 write permit |
| wr_dirty | input | 1 | Dirty bit to store |
| wr_valid | input | 1 | Valid bit to store |
| flush_cmd | input | 1 | Invalidate all non-wired entries |
| ptbr_wr | input | 1 | Page-table base register written |
| victim_idx | output | IDX_W | Suggested slot for the next refill |

## Verification
The bench installs two entries that share a VPN under different ASIDs. A design that ignored the identifier would return one frame for both, or raise a multi-hit. A read-only entry and a clean writable entry then receive writes. A design that checked the wrong permission bit, or ordered the two exceptions wrongly, would report a plain hit. Duplicate entries must resolve to the lower index, and a flush must spare the wired slots. After a refill, the bench touches entries in a known order and follows the LRU victim step by step; an ordering mistake shows up as a stale index. Writes that collide with lookups must leave `lkp_ready` low and the response outputs quiet.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PROT_W  = 2;
  localparam int PROT_RD = 0;
  localparam int PROT_WR = 1;
  localparam int LFSR_W  = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic [2:0] {
    OUT_NONE, OUT_HIT, OUT_MISS, OUT_PFAULT, OUT_DIRTY
  } outcome_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
  input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [ASID_W-1:0]  req_asid,
  output logic               any_match,
  output logic               multi_match,
  output logic [IDX_W-1:0]   first_idx
);
  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] && (ent_vpn[g] == req_vpn) &&
                          (ent_asid[g] == req_asid);
  end

  always_comb begin
    first_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) first_idx = IDX_W'(i);
    end
  end

  assign any_match   = |match_vec;
  assign multi_match = |(match_vec & (match_vec - 1'b1));
endmodule

// File: rtl/tlb_lru_age.sv
module tlb_lru_age #(
  parameter int ENTRIES = 32,
  parameter int WIRED   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)        age_q[i] <= '0;
        else if (age_q[i] < touched_age)   age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic [IDX_W-1:0] best_age;
    oldest_idx = IDX_W'(WIRED);
    best_age   = '0;
    for (int i = WIRED; i < ENTRIES; i++) begin
      if (age_q[i] >= best_age) begin
        best_age   = age_q[i];
        oldest_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_rand_victim.sv
module tlb_rand_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int WIRED   = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SPAN   = ENTRIES - WIRED
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] pick_idx
);
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] folded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lfsr_q <= LFSR_SEED;
    else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ LFSR_TAPS;
    else                lfsr_q <= lfsr_q >> 1;
  end

  assign folded   = lfsr_q % LFSR_W'(SPAN);
  assign pick_idx = IDX_W'(WIRED) + IDX_W'(folded);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES       = 32,
  parameter int WIRED         = 4,
  parameter int VPN_W         = 20,
  parameter int PFN_W         = 20,
  parameter int ASID_W        = 8,
  parameter bit LRU_POLICY    = 1'b1,
  parameter bit FLUSH_ON_PTBR = 1'b1,
  localparam int IDX_W        = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [VPN_W-1:0]  lkp_vpn,
  input  logic [ASID_W-1:0] lkp_asid,
  input  logic              lkp_write,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              rsp_miss,
  output logic              rsp_prot_fault,
  output logic              rsp_dirty_exc,
  output logic              rsp_multi_hit,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PROT_W-1:0] wr_prot,
  input  logic              wr_dirty,
  input  logic              wr_valid,
  input  logic              flush_cmd,
  input  logic              ptbr_wr,
  output logic [IDX_W-1:0]  victim_idx
);
  // Entry storage
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PROT_W-1:0]  prot_q [ENTRIES];

  logic do_flush;
  assign do_flush = flush_cmd || (FLUSH_ON_PTBR && ptbr_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (do_flush) begin
        for (int i = WIRED; i < ENTRIES; i++) valid_q[i] <= 1'b0;
      end
      if (wr_en) valid_q[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]   <= wr_vpn;
      pfn_q[wr_idx]   <= wr_pfn;
      asid_q[wr_idx]  <= wr_asid;
      prot_q[wr_idx]  <= wr_prot;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  // Associative search
  logic             any_match, multi_match;
  logic [IDX_W-1:0] hit_idx;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .ent_valid   (valid_q),
    .ent_vpn     (vpn_q),
    .ent_asid    (asid_q),
    .req_vpn     (lkp_vpn),
    .req_asid    (lkp_asid),
    .any_match   (any_match),
    .multi_match (multi_match),
    .first_idx   (hit_idx)
  );

  // Response classification
  logic     accepted, perm_ok, needs_dirty;
  outcome_e outcome;

  assign lkp_ready   = !(wr_en || do_flush);
  assign accepted    = lkp_valid && lkp_ready;
  assign perm_ok     = lkp_write ? prot_q[hit_idx][PROT_WR] : prot_q[hit_idx][PROT_RD];
  assign needs_dirty = lkp_write && !dirty_q[hit_idx];

  always_comb begin
    if (!accepted)        outcome = OUT_NONE;
    else if (!any_match)  outcome = OUT_MISS;
    else if (!perm_ok)    outcome = OUT_PFAULT;
    else if (needs_dirty) outcome = OUT_DIRTY;
    else                  outcome = OUT_HIT;
  end

  assign rsp_hit        = (outcome == OUT_HIT);
  assign rsp_miss       = (outcome == OUT_MISS);
  assign rsp_prot_fault = (outcome == OUT_PFAULT);
  assign rsp_dirty_exc  = (outcome == OUT_DIRTY);
  assign rsp_multi_hit  = accepted && multi_match;
  assign rsp_pfn        = rsp_hit ? pfn_q[hit_idx] : '0;

  // Replacement victim
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] policy_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = IDX_W'(WIRED);
    for (int i = ENTRIES - 1; i >= WIRED; i--) begin
      if (!valid_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  if (LRU_POLICY) begin : g_lru
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;
    assign touch_en  = wr_en || rsp_hit;
    assign touch_idx = wr_en ? wr_idx : hit_idx;
    tlb_lru_age #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_idx  (touch_idx),
      .oldest_idx (policy_idx)
    );
  end else begin : g_rand
    tlb_rand_victim #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_rand (
      .clk      (clk),
      .rst_n    (rst_n),
      .pick_idx (policy_idx)
    );
  end

  assign victim_idx = free_found ? free_idx : policy_idx;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int ENTRIES = 32,
  parameter int WIRED   = 4,
  parameter int PFN_W   = 20,
  parameter bit FLUSH_ON_PTBR = 1'b1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lkp_valid,
  input logic             lkp_ready,
  input logic             rsp_hit,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic             rsp_miss,
  input logic             rsp_prot_fault,
  input logic             rsp_dirty_exc,
  input logic             rsp_multi_hit,
  input logic             wr_en,
  input logic             flush_cmd,
  input logic             ptbr_wr,
  input logic [IDX_W-1:0] victim_idx
);
  logic acc;
  assign acc = lkp_valid && lkp_ready;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> $countones({rsp_hit, rsp_miss, rsp_prot_fault, rsp_dirty_exc}) == 1); // R3
  AST_PFN_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_pfn == '0); // R3
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || flush_cmd || (FLUSH_ON_PTBR && ptbr_wr)) |-> !lkp_ready); // R12
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |-> !(rsp_hit || rsp_miss || rsp_prot_fault || rsp_dirty_exc || rsp_multi_hit)); // R12
  AST_MULTI_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi_hit |-> !rsp_miss); // R6
  AST_VICTIM_NOT_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(victim_idx) >= WIRED) && (int'(victim_idx) < ENTRIES)); // R9
endmodule

bind asid_tlb tlb_chk #(
  .ENTRIES(ENTRIES), .WIRED(WIRED), .PFN_W(PFN_W), .FLUSH_ON_PTBR(FLUSH_ON_PTBR)
) u_tlb_chk (
  .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_ready(lkp_ready),
  .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_miss(rsp_miss),
  .rsp_prot_fault(rsp_prot_fault), .rsp_dirty_exc(rsp_dirty_exc),
  .rsp_multi_hit(rsp_multi_hit), .wr_en(wr_en), .flush_cmd(flush_cmd),
  .ptbr_wr(ptbr_wr), .victim_idx(victim_idx)
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 32;
  localparam int WIRED   = 4;
  localparam int VPN_W = 20, PFN_W = 20, ASID_W = 8;
  localparam int IDX_W = $clog2(ENTRIES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic lkp_valid = 0, lkp_write = 0;
  logic [VPN_W-1:0] lkp_vpn = '0;
  logic [ASID_W-1:0] lkp_asid = '0;
  logic wr_en = 0, wr_dirty = 0, wr_valid = 0, flush_cmd = 0, ptbr_wr = 0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [VPN_W-1:0] wr_vpn = '0;
  logic [PFN_W-1:0] wr_pfn = '0;
  logic [ASID_W-1:0] wr_asid = '0;
  logic [1:0] wr_prot = '0;

  logic lkp_ready, rsp_hit, rsp_miss, rsp_prot_fault, rsp_dirty_exc, rsp_multi_hit;
  logic [PFN_W-1:0] rsp_pfn;
  logic [IDX_W-1:0] victim_idx;
  logic r_ready, r_hit, r_miss, r_pf, r_de, r_mh;
  logic [PFN_W-1:0] r_pfn;
  logic [IDX_W-1:0] r_victim;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb #(.ENTRIES(ENTRIES), .WIRED(WIRED), .VPN_W(VPN_W), .PFN_W(PFN_W),
             .ASID_W(ASID_W), .LRU_POLICY(1'b1), .FLUSH_ON_PTBR(1'b1)) i_asid_tlb (
    .clk, .rst_n, .lkp_valid, .lkp_ready, .lkp_vpn, .lkp_asid, .lkp_write,
    .rsp_hit, .rsp_pfn, .rsp_miss, .rsp_prot_fault, .rsp_dirty_exc, .rsp_multi_hit,
    .wr_en, .wr_idx, .wr_vpn, .wr_pfn, .wr_asid, .wr_prot, .wr_dirty, .wr_valid,
    .flush_cmd, .ptbr_wr, .victim_idx);

  asid_tlb #(.ENTRIES(ENTRIES), .WIRED(WIRED), .VPN_W(VPN_W), .PFN_W(PFN_W),
             .ASID_W(ASID_W), .LRU_POLICY(1'b0), .FLUSH_ON_PTBR(1'b1)) i_asid_tlb_rnd (
    .clk, .rst_n, .lkp_valid, .lkp_ready(r_ready), .lkp_vpn, .lkp_asid, .lkp_write,
    .rsp_hit(r_hit), .rsp_pfn(r_pfn), .rsp_miss(r_miss), .rsp_prot_fault(r_pf),
    .rsp_dirty_exc(r_de), .rsp_multi_hit(r_mh),
    .wr_en, .wr_idx, .wr_vpn, .wr_pfn, .wr_asid, .wr_prot, .wr_dirty, .wr_valid,
    .flush_cmd, .ptbr_wr, .victim_idx(r_victim));

  // Expected response: {ready, hit, miss, pfault, dirty, multi, pfn}
  typedef struct {
    logic [PFN_W+5:0] vec;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  event ev_sample;
  int   errors = 0, checks = 0;
  bit   done = 0;

  localparam int K_HIT = 0, K_MISS = 1, K_PF = 2, K_DE = 3, K_NONE = 4;

  function automatic logic [PFN_W+5:0] mk(bit rdy, int kind, logic [PFN_W-1:0] pfn, bit multi);
    return {rdy, kind == K_HIT, kind == K_MISS, kind == K_PF, kind == K_DE, multi,
            (kind == K_HIT) ? pfn : {PFN_W{1'b0}}};
  endfunction

  // Monitor: pops expectations and compares against the design
  initial begin
    forever begin
      @(ev_sample);
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [PFN_W+5:0] act;
        e = exp_q.pop_front();
        act = {lkp_ready, rsp_hit, rsp_miss, rsp_prot_fault, rsp_dirty_exc, rsp_multi_hit, rsp_pfn};
        checks++;
        if (act !== e.vec) begin
          errors++;
          $display("FAIL %s: response actual=%h expected=%h", e.tag, act, e.vec);
        end
      end
    end
  end

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver tasks
  task automatic lookup(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid, bit wr,
                        int kind, logic [PFN_W-1:0] pfn, bit multi, string tag);
    exp_t e;
    @(negedge clk);
    lkp_valid = 1; lkp_vpn = vpn; lkp_asid = asid; lkp_write = wr;
    #1;
    e.vec = mk(1'b1, kind, pfn, multi); e.tag = tag;
    exp_q.push_back(e);
    -> ev_sample;
    @(negedge clk);
    lkp_valid = 0;
  endtask

  task automatic install(int idx, logic [VPN_W-1:0] vpn, logic [PFN_W-1:0] pfn,
                         logic [ASID_W-1:0] asid, logic [1:0] prot, bit dirty, bit valid);
    @(negedge clk);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_vpn = vpn; wr_pfn = pfn; wr_asid = asid;
    wr_prot = prot; wr_dirty = dirty; wr_valid = valid;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_flush(bit via_ptbr);
    @(negedge clk);
    if (via_ptbr) ptbr_wr = 1; else flush_cmd = 1;
    @(negedge clk);
    ptbr_wr = 0; flush_cmd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R13: empty after reset
    #1;
    check_val("R13 victim after reset", int'(victim_idx), WIRED);
    check_val("R9 random victim after reset", int'(r_victim), WIRED);
    lookup(20'h00010, 8'd1, 0, K_MISS, '0, 0, "R13 lookup after reset");

    // R1 wired entry 0, R2 same VPN other ASID in slot 5
    install(0, 20'h00010, 20'hA0000, 8'd1, 2'b11, 1, 1);
    lookup(20'h00010, 8'd1, 0, K_HIT, 20'hA0000, 0, "R1 wired hit");
    lookup(20'h00010, 8'd2, 0, K_MISS, '0, 0, "R3 asid mismatch miss");
    install(5, 20'h00010, 20'hB0000, 8'd2, 2'b11, 1, 1);
    lookup(20'h00010, 8'd2, 1, K_HIT, 20'hB0000, 0, "R2 second asid");
    lookup(20'h00010, 8'd1, 0, K_HIT, 20'hA0000, 0, "R2 first asid kept");
    #1 check_val("R9 lowest free non-wired", int'(victim_idx), WIRED);

    // R4 read-only entry, R5 clean writable entry
    install(6, 20'h00200, 20'hC0000, 8'd1, 2'b01, 1, 1);
    lookup(20'h00200, 8'd1, 1, K_PF, '0, 0, "R4 write to read-only");
    lookup(20'h00200, 8'd1, 0, K_HIT, 20'hC0000, 0, "R4 read allowed");
    install(7, 20'h00300, 20'hD0000, 8'd1, 2'b10, 1, 1);
    lookup(20'h00300, 8'd1, 0, K_PF, '0, 0, "R4 read of write-only");
    install(7, 20'h00300, 20'hD0000, 8'd1, 2'b11, 0, 1);
    lookup(20'h00300, 8'd1, 1, K_DE, '0, 0, "R5 write to clean");
    lookup(20'h00300, 8'd1, 0, K_HIT, 20'hD0000, 0, "R5 read of clean");

    // R6 duplicate match
    install(9, 20'h00400, 20'h99999, 8'd1, 2'b11, 1, 1);
    install(8, 20'h00400, 20'h88888, 8'd1, 2'b11, 1, 1);
    lookup(20'h00400, 8'd1, 0, K_HIT, 20'h88888, 1, "R6 lowest index wins");

    // R12 back-pressure during a write
    begin
      exp_t e;
      @(negedge clk);
      wr_en = 1; wr_idx = IDX_W'(10); wr_vpn = 20'h00500; wr_pfn = 20'h55555;
      wr_asid = 8'd1; wr_prot = 2'b11; wr_dirty = 1; wr_valid = 1;
      lkp_valid = 1; lkp_vpn = 20'h00010; lkp_asid = 8'd1; lkp_write = 0;
      #1;
      e.vec = mk(1'b0, K_NONE, '0, 0); e.tag = "R12 stalled during write";
      exp_q.push_back(e);
      -> ev_sample;
      @(negedge clk);
      wr_en = 0; lkp_valid = 0;
    end
    lookup(20'h00500, 8'd1, 0, K_HIT, 20'h55555, 0, "R12 write landed");

    // R7 flush spares wired slot
    pulse_flush(0);
    lookup(20'h00010, 8'd1, 0, K_HIT, 20'hA0000, 0, "R7 wired survives flush");
    lookup(20'h00010, 8'd2, 0, K_MISS, '0, 0, "R7 non-wired flushed");
    #1 check_val("R9 victim after flush", int'(victim_idx), WIRED);

    // R8 flush via page-table base write
    install(5, 20'h00010, 20'hB0000, 8'd2, 2'b11, 1, 1);
    lookup(20'h00010, 8'd2, 0, K_HIT, 20'hB0000, 0, "R8 refilled");
    pulse_flush(1);
    lookup(20'h00010, 8'd2, 0, K_MISS, '0, 0, "R8 ptbr flush");

    // R10 LRU ordering after filling all non-wired slots in order
    for (int i = WIRED; i < ENTRIES; i++)
      install(i, VPN_W'(20'h01000 + i), PFN_W'(i), 8'd3, 2'b11, 1, 1);
    #1 check_val("R10 oldest after fill", int'(victim_idx), WIRED);
    lookup(VPN_W'(20'h01000 + WIRED), 8'd3, 0, K_HIT, PFN_W'(WIRED), 0, "R10 touch");
    #1 check_val("R10 victim after one touch", int'(victim_idx), WIRED + 1);
    lookup(VPN_W'(20'h01000 + WIRED + 1), 8'd3, 0, K_HIT, PFN_W'(WIRED + 1), 0, "R10 touch");
    lookup(VPN_W'(20'h01000 + WIRED + 2), 8'd3, 0, K_HIT, PFN_W'(WIRED + 2), 0, "R10 touch");
    #1 check_val("R10 victim after three touches", int'(victim_idx), WIRED + 3);
    install(WIRED + 3, VPN_W'(20'h01000 + WIRED + 3), PFN_W'(WIRED + 3), 8'd3, 2'b11, 1, 1);
    #1 check_val("R10 write counts as touch", int'(victim_idx), WIRED + 4);

    // R11 random victim range and movement
    begin
      int first_v, in_range, moved;
      first_v = int'(r_victim); in_range = 1; moved = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk); #1;
        if (int'(r_victim) < WIRED || int'(r_victim) >= ENTRIES) in_range = 0;
        if (int'(r_victim) != first_v) moved = 1;
      end
      check_val("R11 random victim in range", in_range, 1);
      check_val("R11 random victim changes", moved, 1);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule